// File: doc/BRIEF.md
# Programmed-I/O Real-Time Clock

This block is a real-time clock that sits on a simple programmed-I/O bus. It holds a 16-bit count that moves forward by a configurable step each time an external prescaler pulses the tick input. The count only moves while the clock is running. Bus commands start the clock, stop it, and read the count. Each command carries a command class and a 4-bit function code. A read answers one cycle later with the count and a skip flag.

An interrupt becomes pending when an advance changes the upper byte of the count. The block compares the upper byte before and after the advance rather than testing the lower byte for zero. This way a carry is still caught when the step is larger than one. The request reaches the `irq` output only while the interrupt-enable bit is set.

A command with any other class or function code changes no state. It raises an illegal-function flag for one cycle instead.

Top module: `rtc_iobus`

## Requirements
- R1: Reset sets the count to zero, leaves the clock running, and clears both the interrupt-enable bit and the pending flag. After reset, `irq`, `rd_skip` and `bad_func` are all low.
- R2: While the clock runs, each cycle with `tick` high adds `step` to the count, modulo 2^16.
- R3: A command with class 0 and function 8 (octal 010) stops the clock and clears the pending flag. The count keeps its value, including when a tick arrives in the same cycle.
- R4: A command with class 0 and function 0 starts the clock and clears the pending flag.
- R5: A command with class 1 and function 0 or 8 is a read. In the next cycle, `rd_skip` is high for one cycle and `rd_data` holds the count as it stood in the cycle of the command.
- R6: The pending flag is set when an advance leaves the upper byte of the count different from its value before the advance. With a step of 1 this happens once every 256 ticks.
- R7: `irq` is high exactly when the pending flag and the interrupt-enable bit are both set. The enable bit is written through `ien_wr` with the value on `ien_wdata`.
- R8: A command with class 2 or 3, or a class 0 or class 1 command whose function code is neither 0 nor 8, raises `bad_func` for one cycle in the next cycle. It leaves the count, the run state and the pending flag unchanged, and it does not raise `rd_skip`.
- R9: While the clock is stopped, ticks are ignored. A read returns the held count.
- R10: When a tick and a start or stop command arrive in the same cycle, the pending flag ends up cleared, even if the tick carried into the upper byte. A start command does not count a tick that arrives in its own cycle while the clock was stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A bus command addressed to the clock is present this cycle |
| cmd_class | input | 2 | Command class: 0 output control, 1 input, 2 output data, 3 sense |
| cmd_func | input | 4 | Function code |
| tick | input | 1 | Tick strobe from the prescaler, one cycle per tick |
| step | input | 16 | Amount added to the count on each tick |
| ien_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ien_wdata | input | 1 | New value of the interrupt-enable bit |
| rd_data | output | 16 | Count captured by the most recent read |
| rd_skip | output | 1 | Skip response, high for one cycle after a read |
| bad_func | output | 1 | Illegal-function flag, high for one cycle after an illegal command |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cmd_class`, `cmd_func`, `tick`, `step` and the enable-write pins are stable and known at every rising edge after reset. They also assume that one cycle carries at most one command. The bench drives every input one time unit after the rising edge and returns each strobe to idle after its cycle. It changes `step` only between ticks. It places ticks next to start and stop commands only in the cycles chosen for R10.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CLS_W = 2;
    localparam int FN_W  = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_CTRL  = 2'd0,
        CLS_IN    = 2'd1,
        CLS_OUT   = 2'd2,
        CLS_SENSE = 2'd3
    } cmd_class_e;

    localparam logic [FN_W-1:0] FN_RUN  = 4'o00;
    localparam logic [FN_W-1:0] FN_HALT = 4'o10;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic bad;
    } cmd_dec_t;

endpackage

// File: rtl/rtc_cmd_dec.sv
module rtc_cmd_dec
    import rtc_pkg::*;
(
    input  logic             valid,
    input  logic [CLS_W-1:0] cls,
    input  logic [FN_W-1:0]  fn,
    output cmd_dec_t         dec
);
    logic fn_known;

    always_comb begin
        fn_known  = (fn == FN_RUN) || (fn == FN_HALT);
        dec.start = valid && (cls == CLS_CTRL) && (fn == FN_RUN);
        dec.stop  = valid && (cls == CLS_CTRL) && (fn == FN_HALT);
        dec.rd    = valid && (cls == CLS_IN) && fn_known;
        dec.bad   = valid && !(dec.start || dec.stop || dec.rd);
    end
endmodule

// File: rtl/rtc_step_add.sv
module rtc_step_add #(
    parameter int CNT_W = 16,
    parameter int LO_W  = 8
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] nxt,
    output logic             hi_chg
);
    localparam int HI_W = CNT_W - LO_W;

    logic [HI_W-1:0] hi_old;
    logic [HI_W-1:0] hi_new;

    always_comb begin
        nxt    = cur + step;
        hi_old = cur[CNT_W-1:LO_W];
        hi_new = nxt[CNT_W-1:LO_W];
        hi_chg = (hi_old != hi_new);
    end
endmodule

// File: rtl/rtc_iobus.sv
module rtc_iobus
    import rtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CLS_W-1:0] cmd_class,
    input  logic [FN_W-1:0]  cmd_func,
    input  logic             tick,
    input  logic [CNT_W-1:0] step,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_skip,
    output logic             bad_func,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             pend;
        logic             ien;
        logic [CNT_W-1:0] rdat;
        logic             skip;
        logic             bad;
    } st_t;

    st_t              st_d;
    st_t              st_q;
    cmd_dec_t         dec;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hi_chg;
    logic             adv;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             pend_q;
    logic             ien_q;

    rtc_cmd_dec u_dec (
        .valid (cmd_valid),
        .cls   (cmd_class),
        .fn    (cmd_func),
        .dec   (dec)
    );

    rtc_step_add #(.CNT_W(CNT_W), .LO_W(LO_W)) u_add (
        .cur    (st_q.cnt),
        .step   (step),
        .nxt    (cnt_nxt),
        .hi_chg (hi_chg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        st_d.bad  = 1'b0;
        adv       = tick && st_q.run && !dec.stop;

        if (adv) begin
            st_d.cnt = cnt_nxt;
            if (hi_chg) begin
                st_d.pend = 1'b1;
            end
        end

        // control commands override the tick for the pending flag
        if (dec.start) begin
            st_d.run  = 1'b1;
            st_d.pend = 1'b0;
        end
        if (dec.stop) begin
            st_d.run  = 1'b0;
            st_d.pend = 1'b0;
        end

        if (ien_wr) begin
            st_d.ien = ien_wdata;
        end

        if (dec.rd) begin
            st_d.rdat = st_q.cnt;
            st_d.skip = 1'b1;
        end
        if (dec.bad) begin
            st_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.run  <= 1'b1;
            st_q.pend <= 1'b0;
            st_q.ien  <= 1'b0;
            st_q.rdat <= '0;
            st_q.skip <= 1'b0;
            st_q.bad  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q    = st_q.cnt;
    assign run_q    = st_q.run;
    assign pend_q   = st_q.pend;
    assign ien_q    = st_q.ien;

    assign rd_data  = st_q.rdat;
    assign rd_skip  = st_q.skip;
    assign bad_func = st_q.bad;
    assign irq      = st_q.pend && st_q.ien;
endmodule

// File: rtl/rtc_iobus_chk.sv
module rtc_iobus_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LO_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [CLS_W-1:0] cmd_class,
    input logic [FN_W-1:0]  cmd_func,
    input logic             tick,
    input logic [CNT_W-1:0] step,
    input logic             ien_wr,
    input logic             ien_wdata,
    input logic [CNT_W-1:0] rd_data,
    input logic             rd_skip,
    input logic             bad_func,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_q,
    input logic             pend_q
);
    logic is_start;
    logic is_stop;
    logic is_rd;
    logic is_bad;

    assign is_start = cmd_valid && (cmd_class == 2'd0) && (cmd_func == 4'd0);
    assign is_stop  = cmd_valid && (cmd_class == 2'd0) && (cmd_func == 4'd8);
    assign is_rd    = cmd_valid && (cmd_class == 2'd1) &&
                      ((cmd_func == 4'd0) || (cmd_func == 4'd8));
    assign is_bad   = cmd_valid && !is_start && !is_stop && !is_rd;

    // R2
    count_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_q && !is_stop) |=> (cnt_q == $past(cnt_q) + $past(step)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || !run_q) |=> $stable(cnt_q));

    // R3
    halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |=> (!run_q && !pend_q && !irq));

    // R4
    run_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |=> (run_q && !pend_q && !irq));

    // R5
    read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (rd_skip && (rd_data == $past(cnt_q))));

    // R6
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> ($past(cnt_q[CNT_W-1:LO_W]) != cnt_q[CNT_W-1:LO_W]));

    // R7
    ien_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !ien_wdata) |=> !irq);

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad |=> (bad_func && !rd_skip));

    // R8
    illegal_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bad && !tick) |=> ($stable(cnt_q) && $stable(run_q) && $stable(pend_q)));
endmodule

bind rtc_iobus rtc_iobus_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_class (cmd_class),
    .cmd_func  (cmd_func),
    .tick      (tick),
    .step      (step),
    .ien_wr    (ien_wr),
    .ien_wdata (ien_wdata),
    .rd_data   (rd_data),
    .rd_skip   (rd_skip),
    .bad_func  (bad_func),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .pend_q    (pend_q)
);

// File: tb/rtc_iobus_tb.sv
module rtc_iobus_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_class = 2'd0;
    logic [3:0]  cmd_func = 4'd0;
    logic        tick = 1'b0;
    logic [15:0] step = 16'd1;
    logic        ien_wr = 1'b0;
    logic        ien_wdata = 1'b0;
    logic [15:0] rd_data;
    logic        rd_skip;
    logic        bad_func;
    logic        irq;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_run, m_pend, m_ien, m_rdat, m_skip, m_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_iobus u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
        .cmd_func(cmd_func), .tick(tick), .step(step), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .rd_data(rd_data), .rd_skip(rd_skip),
        .bad_func(bad_func), .irq(irq)
    );

    task automatic chk(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_run = 1; m_pend = 0; m_ien = 0;
        m_rdat = 0; m_skip = 0; m_bad = 0;
    endtask

    // one clock: predict, wait for the edge, compare, return inputs to idle
    task automatic cyc();
        int is_start, is_stop, is_rd, nxt;
        is_start = cmd_valid && cmd_class == 0 && cmd_func == 0;
        is_stop  = cmd_valid && cmd_class == 0 && cmd_func == 8;
        is_rd    = cmd_valid && cmd_class == 1 && (cmd_func == 0 || cmd_func == 8);
        m_skip = 0;
        m_bad  = (cmd_valid && !is_start && !is_stop && !is_rd) ? 1 : 0;
        if (is_rd) begin
            m_rdat = m_cnt;
            m_skip = 1;
        end
        if (tick && m_run == 1 && !is_stop) begin
            nxt = (m_cnt + int'(step)) % 65536;
            if ((nxt / 256) != (m_cnt / 256)) m_pend = 1;
            m_cnt = nxt;
        end
        if (is_start) begin m_run = 1; m_pend = 0; end
        if (is_stop)  begin m_run = 0; m_pend = 0; end
        if (ien_wr) m_ien = ien_wdata;
        @(posedge clk);
        #1;
        chk(cur_req, "rd_skip", int'(rd_skip), m_skip);
        chk(cur_req, "bad_func", int'(bad_func), m_bad);
        chk(cur_req, "irq", int'(irq), (m_pend && m_ien) ? 1 : 0);
        if (m_skip == 1) chk(cur_req, "rd_data", int'(rd_data), m_rdat);
        cmd_valid = 1'b0;
        tick = 1'b0;
        ien_wr = 1'b0;
    endtask

    task automatic cmd(int cls, int fn, bit with_tick);
        cmd_valid = 1'b1;
        cmd_class = 2'(cls);
        cmd_func  = 4'(fn);
        tick      = with_tick;
        cyc();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
    endtask

    task automatic read_exp(string req, int exp, int fn);
        cmd(1, fn, 1'b0);
        chk(req, "count via read", int'(rd_data), exp);
        chk(req, "skip on read", int'(rd_skip), 1);
    endtask

    task automatic set_ien(bit v);
        ien_wr = 1'b1;
        ien_wdata = v;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "rd_skip after reset", int'(rd_skip), 0);
        chk("R1", "bad_func after reset", int'(bad_func), 0);
        read_exp("R1", 0, 0);
        ticks(1);
        read_exp("R1", 1, 0);              // running out of reset

        // R2: advance by the step
        cur_req = "R2";
        step = 16'd1;
        ticks(4);
        read_exp("R2", 5, 0);
        step = 16'd3;
        ticks(4);
        read_exp("R2", 17, 8);

        // R6 / R7: carry out of the low byte with step 1
        cur_req = "R6";
        set_ien(1'b1);
        step = 16'd1;
        ticks(238);
        chk("R6", "no irq at 255", int'(irq), 0);
        read_exp("R6", 255, 0);
        ticks(1);
        chk("R6", "irq at carry", int'(irq), 1);
        chk("R7", "irq with enable set", int'(irq), 1);

        // R4: start clears pending
        cur_req = "R4";
        cmd(0, 0, 1'b0);
        chk("R4", "irq cleared by start", int'(irq), 0);
        read_exp("R4", 256, 0);

        // R6: large step never lands on a zero low byte
        cur_req = "R6";
        step = 16'd144;
        ticks(1);
        chk("R6", "no carry at 400", int'(irq), 0);
        ticks(1);
        chk("R6", "carry at 544", int'(irq), 1);
        read_exp("R6", 544, 0);

        // R3 / R9: stop, ticks ignored
        cur_req = "R3";
        cmd(0, 8, 1'b0);
        chk("R3", "irq cleared by stop", int'(irq), 0);
        cur_req = "R9";
        ticks(10);
        read_exp("R9", 544, 8);

        // R10: command priority over tick
        cur_req = "R10";
        cmd(0, 0, 1'b1);
        read_exp("R10", 544, 0);
        step = 16'd256;
        ticks(1);
        chk("R10", "pending before start", int'(irq), 1);
        cmd(0, 0, 1'b1);
        chk("R10", "start wins over carry", int'(irq), 0);
        read_exp("R10", 1056, 0);
        cmd(0, 8, 1'b1);
        chk("R10", "stop with tick irq", int'(irq), 0);
        read_exp("R10", 1056, 0);
        cmd(0, 0, 1'b0);

        // R8: illegal commands
        cur_req = "R8";
        ticks(1);
        chk("R8", "pending before illegal", int'(irq), 1);
        cmd(2, 0, 1'b0);
        chk("R8", "flag class 2", int'(bad_func), 1);
        cmd(0, 1, 1'b0);
        chk("R8", "flag ctrl fn 1", int'(bad_func), 1);
        chk("R8", "pending kept", int'(irq), 1);
        cmd(1, 4, 1'b0);
        chk("R8", "no skip on bad read", int'(rd_skip), 0);
        cmd(3, 8, 1'b0);
        chk("R8", "flag class 3", int'(bad_func), 1);
        cur_req = "R5";
        read_exp("R5", 1312, 8);
        chk("R8", "still running", int'(irq), 1);

        // R2 wrap and R7 enable off
        cur_req = "R2";
        cmd(0, 0, 1'b0);
        step = 16'hFEE0;
        ticks(1);
        read_exp("R2", 1024, 0);
        chk("R6", "carry on wrap", int'(irq), 1);
        cur_req = "R7";
        set_ien(1'b0);
        chk("R7", "irq masked", int'(irq), 0);
        set_ien(1'b1);
        chk("R7", "irq unmasked", int'(irq), 1);

        finish_run();
    end
endmodule